// File: doc/BRIEF.md
# Reset Boot-Vector Selector

This block settles, once per reset, where the processor begins executing. Three sources compete. An active-low boot-request pin has first priority. A nonvolatile boot-jump bit comes second. The standard case applies when neither is active. The result sets the initial program counter, the initial value for the flash-control register and the boot-enable state. While boot enable is high, instruction fetches that land in the top 4 KB of code space are steered to a separate boot region instead of user flash.

The block also holds a small auxiliary register that the CPU can read and write. It carries the boot-enable bit, a general-purpose flag and the select bit for two data pointers. Every other bit reads as zero, and bit 2 is deliberately kept at zero. Software can therefore read the register, add one and write it back: this flips the pointer select and leaves the flag and boot enable as they were. The two 16-bit data pointers are included. They share one low/high byte write port, which always addresses the selected pointer.

Top module: `boot_vector_map`

## Requirements
- R1: If the boot-request pin is low when reset is released, then boot_en=1, rst_pc=F000h and rst_fcon=00h.
- R2: If the pin is high and the boot-jump bit is programmed (1), then boot_en=1, rst_pc=F000h and rst_fcon=F0h.
- R3: If the pin is high and the boot-jump bit is 0, then boot_en=0, rst_pc=0000h and rst_fcon=F0h.
- R4: A low pin wins over a programmed boot-jump bit and gives rst_fcon=00h.
- R5: The decision is taken once, on the third clock edge after rst_n rises. Later changes on the pin or the jump bit have no effect on rst_pc, rst_fcon or boot_en.
- R6: fetch_boot_sel is 1 exactly when boot_en=1 and fetch_addr lies in F000h–FFFFh.
- R7: A write to the auxiliary register loads boot_en from write-data bit 5, and fetch_boot_sel follows the new value.
- R8: aux_rdata shows boot_en at bit 5, the general flag at bit 3 and the pointer select at bit 0. Bits 7, 6, 4, 2 and 1 always read 0.
- R9: Writing back aux_rdata+1 toggles the pointer select and leaves boot_en and the flag unchanged.
- R10: There are two 16-bit data pointers, selected by bit 0 (0 = pointer 0). A low- or high-byte write changes only that byte of the selected pointer, and dp_value shows the selected pointer.
- R11: While rst_n is low: boot_en=0, rst_pc=0000h, rst_fcon=F0h, aux_rdata=00h and dp_value=0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req_n | input | 1 | Asynchronous boot-request pin, low requests boot |
| nv_jump_prog | input | 1 | Nonvolatile boot-jump bit, 1 = programmed |
| aux_wr | input | 1 | Auxiliary register write strobe |
| aux_wdata | input | 8 | Auxiliary register write data |
| aux_rdata | output | 8 | Auxiliary register read value |
| fetch_addr | input | 16 | Instruction fetch address |
| fetch_boot_sel | output | 1 | Fetch goes to the boot region |
| rst_pc | output | 16 | Initial program counter |
| rst_fcon | output | 8 | Initial flash-control value |
| boot_en | output | 1 | Boot region mapped |
| dp_wr_lo | input | 1 | Write low byte of the selected data pointer |
| dp_wr_hi | input | 1 | Write high byte of the selected data pointer |
| dp_wdata | input | 8 | Data pointer byte write data |
| dp_sel | output | 1 | Current data pointer select |
| dp_value | output | 16 | Selected data pointer value |

## Verification
The bench drives the pin low together with a programmed jump bit. A selector with the wrong priority would return F0h instead of 00h for the flash-control value. After a decision it toggles both boot sources, which exposes a selector that tracks its inputs instead of latching them once. It writes back the incremented register value twice. If bit 1 or bit 2 were stored or read back, the flag or the select would change wrongly. Fetches are probed on both sides of the F000h boundary, including EFFFh. Data pointer writes are checked to land only in the selected pointer, so cross-writes between the two pointers would be caught.

// File: rtl/bvm_pkg.sv
package bvm_pkg;

  typedef enum logic [1:0] {
    SRC_STD  = 2'd0,
    SRC_JUMP = 2'd1,
    SRC_PIN  = 2'd2
  } boot_src_e;

  localparam int AUX_W        = 8;
  localparam int AUX_BOOT_BIT = 5;
  localparam int AUX_FLAG_BIT = 3;
  localparam int AUX_ZERO_BIT = 2;
  localparam int AUX_DPS_BIT  = 0;

endpackage

// File: rtl/bvm_reset_sync.sv
module bvm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[STAGES-1];

endmodule

// File: rtl/bvm_boot_decide.sv
module bvm_boot_decide
  import bvm_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter int                BOOT_AW       = 12,
  parameter int                FCON_W        = 8,
  parameter logic [FCON_W-1:0] FCON_PIN_INIT = 8'h00,
  parameter logic [FCON_W-1:0] FCON_STD_INIT = 8'hF0,
  parameter int                SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n_sync,
  input  logic              boot_req_n,
  input  logic              nv_jump_prog,
  output logic              load_en,
  output logic              boot_init,
  output logic [ADDR_W-1:0] rst_pc,
  output logic [FCON_W-1:0] rst_fcon
);

  localparam logic [ADDR_W-1:0] BOOT_VEC =
    {{(ADDR_W-BOOT_AW){1'b1}}, {BOOT_AW{1'b0}}};

  // pin synchroniser: free running, carries no reset
  logic [SYNC_STAGES-1:0] pin_q;
  logic                   pin_s;

  always_ff @(posedge clk) begin
    pin_q <= {pin_q[SYNC_STAGES-2:0], boot_req_n};
  end
  assign pin_s = pin_q[SYNC_STAGES-1];

  boot_src_e src_q, src_d;
  logic      done_q, done_d;

  always_comb begin
    src_d  = src_q;
    done_d = done_q;
    if (!done_q) begin
      done_d = 1'b1;
      if (!pin_s)            src_d = SRC_PIN;
      else if (nv_jump_prog) src_d = SRC_JUMP;
      else                   src_d = SRC_STD;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      src_q  <= SRC_STD;
      done_q <= 1'b0;
    end else if (!done_q) begin
      src_q  <= src_d;
      done_q <= done_d;
    end
  end

  assign load_en   = !done_q;
  assign boot_init = (src_d != SRC_STD);

  always_comb begin
    rst_pc   = (src_q == SRC_STD) ? '0 : BOOT_VEC;
    rst_fcon = (src_q == SRC_PIN) ? FCON_PIN_INIT : FCON_STD_INIT;
  end

  a_r1_pin_vector: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (load_en && !pin_s) |=> (rst_pc == BOOT_VEC && rst_fcon == FCON_PIN_INIT));

  a_r2_jump_vector: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (load_en && pin_s && nv_jump_prog) |=> (rst_pc == BOOT_VEC && rst_fcon == FCON_STD_INIT));

  a_r3_std_vector: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (load_en && pin_s && !nv_jump_prog) |=> (rst_pc == '0 && rst_fcon == FCON_STD_INIT));

  a_r5_decide_once: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !load_en |=> ($stable(rst_pc) && $stable(rst_fcon) && !load_en));

endmodule

// File: rtl/bvm_aux_reg.sv
module bvm_aux_reg
  import bvm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n_sync,
  input  logic             load_en,
  input  logic             boot_init,
  input  logic             wr,
  input  logic [AUX_W-1:0] wdata,
  output logic [AUX_W-1:0] rdata,
  output logic             boot_en,
  output logic             dps
);

  logic boot_q, boot_d;
  logic flag_q, flag_d;
  logic dps_q,  dps_d;
  logic en;

  always_comb begin
    boot_d = boot_q;
    flag_d = flag_q;
    dps_d  = dps_q;
    if (load_en) begin
      boot_d = boot_init;
    end else if (wr) begin
      boot_d = wdata[AUX_BOOT_BIT];
      flag_d = wdata[AUX_FLAG_BIT];
      dps_d  = wdata[AUX_DPS_BIT];
    end
  end

  assign en = load_en | wr;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      boot_q <= 1'b0;
      flag_q <= 1'b0;
      dps_q  <= 1'b0;
    end else if (en) begin
      boot_q <= boot_d;
      flag_q <= flag_d;
      dps_q  <= dps_d;
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[AUX_BOOT_BIT] = boot_q;
    rdata[AUX_FLAG_BIT] = flag_q;
    rdata[AUX_DPS_BIT]  = dps_q;
  end

  assign boot_en = boot_q;
  assign dps     = dps_q;

  a_r7_sw_boot_write: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr && !load_en) |=> (boot_en == $past(wdata[AUX_BOOT_BIT])));

  a_r9_dps_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !wr |=> $stable(dps));

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !wr |=> $stable(rdata[AUX_FLAG_BIT]));

endmodule

// File: rtl/bvm_dptr_bank.sv
module bvm_dptr_bank #(
  parameter int DP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n_sync,
  input  logic              sel,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DP_W/2-1:0] wdata,
  output logic [DP_W-1:0]   value
);

  localparam int BYTE_W = DP_W / 2;
  localparam int NPTR   = 2;

  logic [NPTR-1:0][DP_W-1:0] ptr_v;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [DP_W-1:0] q, d;
    logic            hit, en;

    assign hit = (sel == g[0]);
    assign en  = hit & (wr_lo | wr_hi);

    always_comb begin
      d = q;
      if (wr_lo) d[BYTE_W-1:0]    = wdata;
      if (wr_hi) d[DP_W-1:BYTE_W] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n_sync) begin
      if (!rst_n_sync) q <= '0;
      else if (en)     q <= d;
    end

    assign ptr_v[g] = q;
  end

  assign value = ptr_v[sel];

  a_r10_lo_lands: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_lo && $stable(sel)) |=> (($past(sel) != sel) || value[BYTE_W-1:0] == $past(wdata)));

  a_r10_hi_lands: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_hi && $stable(sel)) |=> (($past(sel) != sel) || value[DP_W-1:BYTE_W] == $past(wdata)));

endmodule

// File: rtl/boot_vector_map.sv
module boot_vector_map
  import bvm_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BOOT_AW = 12,
  parameter int FCON_W  = 8,
  parameter int DP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_req_n,
  input  logic              nv_jump_prog,
  input  logic              aux_wr,
  input  logic [AUX_W-1:0]  aux_wdata,
  output logic [AUX_W-1:0]  aux_rdata,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_boot_sel,
  output logic [ADDR_W-1:0] rst_pc,
  output logic [FCON_W-1:0] rst_fcon,
  output logic              boot_en,
  input  logic              dp_wr_lo,
  input  logic              dp_wr_hi,
  input  logic [DP_W/2-1:0] dp_wdata,
  output logic              dp_sel,
  output logic [DP_W-1:0]   dp_value
);

  localparam int TAG_W = ADDR_W - BOOT_AW;

  logic rst_n_sync;
  logic load_en;
  logic boot_init;

  bvm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bvm_boot_decide #(
    .ADDR_W        (ADDR_W),
    .BOOT_AW       (BOOT_AW),
    .FCON_W        (FCON_W),
    .FCON_PIN_INIT ('0),
    .FCON_STD_INIT ({{(FCON_W-4){1'b1}}, 4'h0}),
    .SYNC_STAGES   (2)
  ) u_decide (
    .clk          (clk),
    .rst_n_sync   (rst_n_sync),
    .boot_req_n   (boot_req_n),
    .nv_jump_prog (nv_jump_prog),
    .load_en      (load_en),
    .boot_init    (boot_init),
    .rst_pc       (rst_pc),
    .rst_fcon     (rst_fcon)
  );

  bvm_aux_reg u_aux (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .load_en    (load_en),
    .boot_init  (boot_init),
    .wr         (aux_wr),
    .wdata      (aux_wdata),
    .rdata      (aux_rdata),
    .boot_en    (boot_en),
    .dps        (dp_sel)
  );

  bvm_dptr_bank #(.DP_W(DP_W)) u_dptr (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .sel        (dp_sel),
    .wr_lo      (dp_wr_lo),
    .wr_hi      (dp_wr_hi),
    .wdata      (dp_wdata),
    .value      (dp_value)
  );

  assign fetch_boot_sel = boot_en && (fetch_addr[ADDR_W-1:BOOT_AW] == {TAG_W{1'b1}});

  a_r6_sel_needs_boot: assert property (@(posedge clk) disable iff (!rst_n_sync)
    fetch_boot_sel |-> (boot_en && fetch_addr >= rst_pc));

endmodule

// File: tb/boot_vector_map_test.sv
module boot_vector_map_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_req_n;
  logic        nv_jump_prog;
  logic        aux_wr;
  logic [7:0]  aux_wdata;
  logic [7:0]  aux_rdata;
  logic [15:0] fetch_addr;
  logic        fetch_boot_sel;
  logic [15:0] rst_pc;
  logic [7:0]  rst_fcon;
  logic        boot_en;
  logic        dp_wr_lo, dp_wr_hi;
  logic [7:0]  dp_wdata;
  logic        dp_sel;
  logic [15:0] dp_value;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  boot_vector_map uut (
    .clk(clk), .rst_n(rst_n), .boot_req_n(boot_req_n), .nv_jump_prog(nv_jump_prog),
    .aux_wr(aux_wr), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
    .fetch_addr(fetch_addr), .fetch_boot_sel(fetch_boot_sel),
    .rst_pc(rst_pc), .rst_fcon(rst_fcon), .boot_en(boot_en),
    .dp_wr_lo(dp_wr_lo), .dp_wr_hi(dp_wr_hi), .dp_wdata(dp_wdata),
    .dp_sel(dp_sel), .dp_value(dp_value)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic pin, input logic jump);
    @(negedge clk);
    rst_n = 1'b0; boot_req_n = pin; nv_jump_prog = jump;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic aux_write(input logic [7:0] v);
    @(negedge clk);
    aux_wr = 1'b1; aux_wdata = v;
    @(negedge clk);
    aux_wr = 1'b0;
  endtask

  task automatic dp_write(input logic hi, input logic [7:0] v);
    @(negedge clk);
    dp_wr_lo = !hi; dp_wr_hi = hi; dp_wdata = v;
    @(negedge clk);
    dp_wr_lo = 1'b0; dp_wr_hi = 1'b0;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 boot_en", boot_en, 0);
    chk("R11 rst_pc", rst_pc, 16'h0000);
    chk("R11 rst_fcon", rst_fcon, 8'hF0);
    chk("R11 aux_rdata", aux_rdata, 8'h00);
    chk("R11 dp_value", dp_value, 16'h0000);
  endtask

  task automatic t_boot_pin;
    do_reset(1'b0, 1'b0);
    chk("R1 boot_en", boot_en, 1);
    chk("R1 rst_pc", rst_pc, 16'hF000);
    chk("R1 rst_fcon", rst_fcon, 8'h00);
  endtask

  task automatic t_boot_jump;
    do_reset(1'b1, 1'b1);
    chk("R2 boot_en", boot_en, 1);
    chk("R2 rst_pc", rst_pc, 16'hF000);
    chk("R2 rst_fcon", rst_fcon, 8'hF0);
  endtask

  task automatic t_boot_std;
    do_reset(1'b1, 1'b0);
    chk("R3 boot_en", boot_en, 0);
    chk("R3 rst_pc", rst_pc, 16'h0000);
    chk("R3 rst_fcon", rst_fcon, 8'hF0);
  endtask

  task automatic t_priority;
    do_reset(1'b0, 1'b1);
    chk("R4 rst_fcon", rst_fcon, 8'h00);
    chk("R4 rst_pc", rst_pc, 16'hF000);
    chk("R4 boot_en", boot_en, 1);
  endtask

  task automatic t_once;
    do_reset(1'b1, 1'b0);
    boot_req_n = 1'b0; nv_jump_prog = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 rst_pc", rst_pc, 16'h0000);
    chk("R5 rst_fcon", rst_fcon, 8'hF0);
    chk("R5 boot_en", boot_en, 0);
    boot_req_n = 1'b1; nv_jump_prog = 1'b0;
  endtask

  task automatic t_fetch;
    do_reset(1'b1, 1'b1);
    fetch_addr = 16'hF000; #1; chk("R6 F000", fetch_boot_sel, 1);
    fetch_addr = 16'hFFFF; #1; chk("R6 FFFF", fetch_boot_sel, 1);
    fetch_addr = 16'hEFFF; #1; chk("R6 EFFF", fetch_boot_sel, 0);
    fetch_addr = 16'h0000; #1; chk("R6 0000", fetch_boot_sel, 0);
    aux_write(8'h00);
    fetch_addr = 16'hF800; #1;
    chk("R7 clear boot_en", boot_en, 0);
    chk("R7 sel off", fetch_boot_sel, 0);
    aux_write(8'h20);
    #1;
    chk("R7 set boot_en", boot_en, 1);
    chk("R7 sel on", fetch_boot_sel, 1);
  endtask

  task automatic t_aux;
    do_reset(1'b1, 1'b0);
    aux_write(8'hFF);
    chk("R8 all ones", aux_rdata, 8'h29);
    aux_write(8'h08);
    chk("R8 flag only", aux_rdata, 8'h08);
  endtask

  task automatic t_inc;
    do_reset(1'b1, 1'b0);
    aux_write(8'h28);
    aux_write(aux_rdata + 8'd1);
    chk("R9 inc set dps", aux_rdata, 8'h29);
    chk("R9 dp_sel 1", dp_sel, 1);
    aux_write(aux_rdata + 8'd1);
    chk("R9 inc clear dps", aux_rdata, 8'h28);
    chk("R9 boot_en kept", boot_en, 1);
  endtask

  task automatic t_dptr;
    do_reset(1'b1, 1'b0);
    dp_write(1'b0, 8'h34);
    dp_write(1'b1, 8'h12);
    chk("R10 ptr0", dp_value, 16'h1234);
    aux_write(8'h01);
    chk("R10 ptr1 clean", dp_value, 16'h0000);
    dp_write(1'b0, 8'hCD);
    chk("R10 ptr1 lo", dp_value, 16'h00CD);
    dp_write(1'b1, 8'hAB);
    chk("R10 ptr1", dp_value, 16'hABCD);
    aux_write(8'h00);
    chk("R10 ptr0 kept", dp_value, 16'h1234);
  endtask

  initial begin
    rst_n = 1'b0; boot_req_n = 1'b1; nv_jump_prog = 1'b0;
    aux_wr = 1'b0; aux_wdata = '0; fetch_addr = '0;
    dp_wr_lo = 1'b0; dp_wr_hi = 1'b0; dp_wdata = '0;
    t_reset_state();
    t_boot_pin();
    t_boot_jump();
    t_boot_std();
    t_priority();
    t_once();
    t_fetch();
    t_aux();
    t_inc();
    t_dptr();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule